// File: doc/BRIEF.md
# Programmable Watchdog with Steering

This block is a watchdog timer set up through a single 8-bit control register. The register carries a five-bit multiplier, a two-bit resolution code and a steering bit. The block counts pulses of an enable input that arrives once every sixteenth of a second. The timeout, in those units, is the multiplier scaled by four raised to the resolution code. Software keeps the watchdog alive by accessing the register. Any write stores a new value and restarts the count. Any read restarts the count with the value already stored.

When the count runs out, the block raises a sticky expiry flag. The steering bit then chooses what else happens. With steering clear, the block sends a single interrupt pulse and the counter stops until the next restart. With steering set, the block clears the control register and sends a one-cycle reset request to the system reset logic. That logic sits outside this block.

Top module: `wdog_steer`

## Requirements
- R1: After reset the control register reads 0x00, and the flag, the interrupt pulse and the reset request are all low.
- R2: A write stores wdata_i in the control register. rdata_o shows the stored value from the cycle after the write.
- R3: Control register fields are steer = bit 7, multiplier = bits 6:2 and resolution = bits 1:0. After a restart, expiry happens on exactly the (multiplier << (2*resolution))-th tick_i pulse, counting the first tick in a cycle after the restart. The flag and the pulse show in the cycle after that tick.
- R4: A register value of zero, or a multiplier of zero with any resolution code, disables the watchdog, and no expiry ever follows.
- R5: A write clears the expiry flag and restarts the countdown from the newly written value.
- R6: A read (rd_i) restarts the countdown from the value in the register and does not change that value.
- R7: On expiry the flag (flag_o) goes high and stays high until the next write.
- R8: With steer = 1, expiry clears the control register to 0x00 and gives a reset request exactly one cycle long, with no interrupt.
- R9: With steer = 0, expiry gives exactly one one-cycle interrupt pulse and no reset request. The register keeps its value, and no further pulse follows until a restart.
- R10: Clock cycles without tick_i do not advance the countdown.
- R11: A restart in the same cycle as the final tick takes priority: no expiry happens, and the full timeout starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable, once per 1/16 second |
| rd_i | input | 1 | Control register read strobe |
| wr_i | input | 1 | Control register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Control register contents |
| flag_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | One-cycle interrupt pulse on steer=0 expiry |
| rst_req_o | output | 1 | One-cycle reset request on steer=1 expiry |

## Verification
The assertions check on every cycle the properties that need no count:
- the interrupt and the reset request never appear together;
- each pulse lasts a single cycle;
- a reset request always comes with a cleared register and a raised flag;
- a write stores its data and drops the flag;
- the flag can rise only on a tick, and never while the multiplier is zero.

Only the bench's scenarios can show that the expiry lands on exactly the computed tick for each field combination. The same holds for a read restoring the full timeout, for a restart winning over the final tick, and for the counter staying stopped after an interrupt expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned WD_MULT_W = 5;
  localparam int unsigned WD_RES_W  = 2;

  typedef enum logic [1:0] {
    RS_NONE  = 2'd0,
    RS_WRITE = 2'd1,
    RS_READ  = 2'd2
  } restart_e;
endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg #(
  parameter int unsigned MULT_W = 5,
  parameter int unsigned RES_W  = 2,
  localparam int unsigned DATA_W  = 1 + MULT_W + RES_W,
  localparam int unsigned RES_N   = 1 << RES_W,
  localparam int unsigned CNT_W   = MULT_W + 2 * (RES_N - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] cfg_o,
  output logic              steer_o,
  output logic [CNT_W-1:0]  timeout_o
);
  logic [DATA_W-1:0] cfg_q;
  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  res;
  logic [CNT_W-1:0]  scaled [RES_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_q <= '0;
    else if (wr_i)  cfg_q <= wdata_i;
    else if (clr_i) cfg_q <= '0;
  end

  assign mult    = cfg_q[RES_W +: MULT_W];
  assign res     = cfg_q[RES_W-1:0];
  assign steer_o = cfg_q[DATA_W-1];
  assign cfg_o   = cfg_q;

  // one pre-shifted candidate per resolution code
  for (genvar r = 0; r < RES_N; r++) begin : g_scale
    assign scaled[r] = {{(CNT_W-MULT_W){1'b0}}, mult} << (2 * r);
  end

  assign timeout_o = scaled[res];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= load_i;
      run_q <= |load_i;
    end else if (tick_i && run_q) begin
      cnt_q <= cnt_q - LAST;
      if (cnt_q == LAST) run_q <= 1'b0;
    end
  end

  // restart in the same cycle suppresses expiry
  assign expire_o = tick_i && run_q && (cnt_q == LAST) && !restart_i;
endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic steer_i,
  input  logic flag_clr_i,
  output logic flag_o,
  output logic irq_o,
  output logic rst_req_o,
  output logic cfg_clr_o
);
  logic flag_q, irq_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      irq_q <= expire_i && !steer_i;
      req_q <= expire_i && steer_i;
      if (expire_i)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign cfg_clr_o = expire_i && steer_i;
  assign flag_o    = flag_q;
  assign irq_o     = irq_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
  import wdog_pkg::*;
#(
  parameter int unsigned MULT_W = WD_MULT_W,
  parameter int unsigned RES_W  = WD_RES_W,
  localparam int unsigned DATA_W = 1 + MULT_W + RES_W,
  localparam int unsigned CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  restart_e         restart_src;
  logic             restart;
  logic             cfg_clr;
  logic             steer;
  logic             expire;
  logic [CNT_W-1:0] timeout;
  logic [CNT_W-1:0] wr_timeout;
  logic [CNT_W-1:0] load_val;
  logic [MULT_W-1:0] wr_mult;
  logic [RES_W-1:0]  wr_res;

  always_comb begin
    if (wr_i)      restart_src = RS_WRITE;
    else if (rd_i) restart_src = RS_READ;
    else           restart_src = RS_NONE;
  end
  assign restart = (restart_src != RS_NONE);

  // a write loads the incoming value's timeout, a read the stored one
  assign wr_mult    = wdata_i[RES_W +: MULT_W];
  assign wr_res     = wdata_i[RES_W-1:0];
  assign wr_timeout = {{(CNT_W-MULT_W){1'b0}}, wr_mult} << (2 * wr_res);
  assign load_val   = (restart_src == RS_WRITE) ? wr_timeout : timeout;

  wdog_cfg_reg #(.MULT_W(MULT_W), .RES_W(RES_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .clr_i     (cfg_clr),
    .cfg_o     (rdata_o),
    .steer_o   (steer),
    .timeout_o (timeout)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .restart_i (restart),
    .load_i    (load_val),
    .expire_o  (expire)
  );

  wdog_expiry u_exp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .expire_i   (expire),
    .steer_i    (steer),
    .flag_clr_i (wr_i),
    .flag_o     (flag_o),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o),
    .cfg_clr_o  (cfg_clr)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int unsigned MULT_W = 5,
  parameter int unsigned RES_W  = 2,
  localparam int unsigned DATA_W = 1 + MULT_W + RES_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              flag_o,
  input logic              irq_o,
  input logic              rst_req_o
);
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && rst_req_o));                                          // R8
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);                                               // R9
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);                                       // R8
  AST_REQ_CLEARS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (rdata_o == '0));                                  // R8
  AST_PULSE_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || rst_req_o) |-> flag_o);                                // R7
  AST_WR_DROPS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !flag_o);                                               // R5
  AST_WR_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (rdata_o == $past(wdata_i)));                           // R2
  AST_FLAG_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i == 1'b0) |=> !$rose(flag_o));                            // R10
  AST_ZERO_MULT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[RES_W +: MULT_W] == '0) |=> !$rose(flag_o));            // R4
endmodule

bind wdog_steer wdog_chk #(.MULT_W(MULT_W), .RES_W(RES_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .flag_o    (flag_o),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o)
);

// File: tb/wdog_steer_tb.sv
module wdog_steer_tb;
  localparam int CLK_P = 10;
  localparam int NVEC  = 8;
  // {cfg value, expected timeout in ticks (0 = disabled)}
  localparam logic [18:0] VEC [NVEC] = '{
    {8'h04, 11'd1},    {8'h09, 11'd8},   {8'h0E, 11'd48}, {8'h7F, 11'd1984},
    {8'h7C, 11'd31},   {8'h03, 11'd0},   {8'h00, 11'd0},  {8'h15, 11'd20}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       flag, irq, rreq;
  int checks = 0, errors = 0;
  int pulses;

  always #(CLK_P/2) clk = ~clk;

  wdog_steer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .flag_o(flag), .irq_o(irq),
    .rst_req_o(rreq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic r, input logic w, input logic [7:0] d);
    tick = t; rd = r; wr = w; wdata = d;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; rd = 1'b0; wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 8'h00);
      if (irq || rreq) pulses++;
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      if (irq || rreq) pulses++;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 cfg", rdata, 0); chk("R1 flag", flag, 0);
    chk("R1 irq", irq, 0);   chk("R1 req", rreq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: steer=0 timeouts and disabled codes (R3 R4 R5 R7 R9)
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0]  cv;
      logic [10:0] tv;
      cv = VEC[v][18:11]; tv = VEC[v][10:0];
      cyc(1'b0, 1'b0, 1'b1, cv);
      chk("R2 store", rdata, cv);
      chk("R5 flag cleared", flag, 0);
      pulses = 0;
      if (tv == 0) begin
        ticks(100);
        chk("R4 disabled flag", flag, 0);
        chk("R4 disabled pulses", pulses, 0);
      end else begin
        ticks(int'(tv) - 1);
        chk("R3 before timeout", flag, 0);
        cyc(1'b1, 1'b0, 1'b0, 8'h00);
        chk("R3 flag at timeout", flag, 1);
        chk("R9 irq pulse", irq, 1);
        chk("R9 no reset req", rreq, 0);
        cyc(1'b0, 1'b0, 1'b0, 8'h00);
        chk("R9 irq one cycle", irq, 0);
        pulses = 0;
        ticks(20);
        chk("R9 stopped", pulses, 0);
        chk("R7 flag sticky", flag, 1);
        chk("R9 cfg kept", rdata, cv);
      end
    end

    // R10: idle cycles without tick
    cyc(1'b0, 1'b0, 1'b1, 8'h04);
    repeat (20) cyc(1'b0, 1'b0, 1'b0, 8'h00);
    chk("R10 no tick no expiry", flag, 0);
    cyc(1'b1, 1'b0, 1'b0, 8'h00);
    chk("R10 tick expires", flag, 1);

    // R6: read restarts with stored value
    cyc(1'b0, 1'b0, 1'b1, 8'h0C);
    ticks(2);
    cyc(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R6 read keeps cfg", rdata, 8'h0C);
    ticks(2);
    chk("R6 restarted", flag, 0);
    ticks(1);
    chk("R6 expires after full timeout", flag, 1);

    // R11: restart on the final tick
    cyc(1'b0, 1'b0, 1'b1, 8'h08);
    ticks(1);
    cyc(1'b1, 1'b1, 1'b0, 8'h00);
    chk("R11 restart wins", flag, 0);
    chk("R11 no irq", irq, 0);
    ticks(1);
    chk("R11 full timeout pending", flag, 0);
    ticks(1);
    chk("R11 expiry later", flag, 1);

    // R8: steered to reset
    cyc(1'b0, 1'b0, 1'b1, 8'h84);
    chk("R5 flag cleared by write", flag, 0);
    cyc(1'b1, 1'b0, 1'b0, 8'h00);
    chk("R8 reset req", rreq, 1);
    chk("R8 no irq", irq, 0);
    chk("R8 cfg cleared", rdata, 0);
    chk("R7 flag set", flag, 1);
    cyc(1'b0, 1'b0, 1'b0, 8'h00);
    chk("R8 req one cycle", rreq, 0);
    cyc(1'b0, 1'b1, 1'b0, 8'h00);
    pulses = 0;
    ticks(30);
    chk("R8 quiet after clear", pulses, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule